// File: doc/BRIEF.md
# Video Memory SDRAM Controller

This block drives a single 16-bit SDRAM that serves as the frame store of a display controller. It takes one word request at a time from the internal side: a word address, a read/write flag, write data and two byte enables. It turns each request into an ACTIVATE and then one READ or WRITE with auto-precharge. After reset it runs a fixed power-up sequence. During normal operation it inserts AUTO REFRESH commands at a fixed interval.

A static strap input, `small_mode`, selects one of two memory sizes. When high, the part is a two-bank 16 Mbit device with 11-bit rows and 8-bit columns, and the bank select travels on the top address pin. When low, the part is a four-bank 64 Mbit device with 12-bit rows and 8-bit columns, and the bank goes out on the two bank pins. Command outputs are registered and change on the rising clock. Read data is captured on a rising edge a fixed number of cycles after the READ.

Top module: `vram_sdram_ctrl`

## Requirements
- R1: Once reset is released, the first four commands are PRECHARGE ALL (address bit 10 high), AUTO REFRESH, AUTO REFRESH, then MODE REGISTER SET. The MODE REGISTER SET drives address value 0x020 (CAS latency 2, burst length 1) with the bank pins at 0.
- R2: The command is encoded on {cs_n, ras_n, cas_n, we_n} as follows: ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, MODE SET 0000. cs_n is high in every cycle that carries no command, including the whole reset period.
- R3: With `small_mode` low, the word address is split as {bank[21:20], row[19:8], column[7:0]}. ACTIVATE drives the bank on `sd_ba` and the row on `sd_addr[11:0]`. READ and WRITE drive the same bank and put the column on `sd_addr[7:0]`.
- R4: With `small_mode` high, the word address is split as {bank[19], row[18:8], column[7:0]}. Address bits 21:20 are ignored. `sd_ba` stays 0. `sd_addr[11]` carries the bank on ACTIVATE, READ and WRITE. ACTIVATE puts the row on `sd_addr[10:0]`.
- R5: On every READ and WRITE, `sd_addr[10]` is high to request auto-precharge, and `sd_addr[9:8]` are low.
- R6: READ or WRITE follows its ACTIVATE after exactly T_RCD cycles. Two ACTIVATEs are at least T_RC cycles apart. Any command after a PRECHARGE waits at least T_RP cycles.
- R7: After initialization, AUTO REFRESH commands recur with a spacing within REF_INTERVAL ± (T_RCD + max(T_RC−T_RCD, T_RP+2) + 2) cycles, even under continuous requests. No command follows an AUTO REFRESH within T_RC cycles.
- R8: When a refresh is due and the controller is idle, AUTO REFRESH is issued before any waiting request is accepted.
- R9: `req_ack` is a one-cycle pulse. It is high in exactly the cycle in which the ACTIVATE for the accepted request is on the bus.
- R10: During a WRITE, `sd_dq_oe` is high and `sd_dq_out` carries the write data. `sd_dqm_hi` equals the inverse of `req_be[1]` (bits 15..8), and `sd_dqm_lo` equals the inverse of `req_be[0]` (bits 7..0). In every other cycle `sd_dq_oe` is low.
- R11: `rd_valid` pulses for one cycle, three cycles after the READ cycle. `rd_data` then carries the word the memory presented at CAS latency 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| small_mode | input | 1 | High: two-bank 16 Mbit part; low: four-bank 64 Mbit part |
| req | input | 1 | Request pending, held until acknowledged |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = upper byte |
| req_ack | output | 1 | Request accepted (one cycle) |
| rd_valid | output | 1 | Read data strobe (one cycle) |
| rd_data | output | 16 | Read data |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | Row address strobe |
| sd_cas_n | output | 1 | Column address strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank pins |
| sd_addr | output | ROW_W | Multiplexed row/column address |
| sd_dqm_hi | output | 1 | Mask for data bits 15..8 |
| sd_dqm_lo | output | 1 | Mask for data bits 7..0 |
| sd_dq_out | output | 16 | Write data to the SDRAM |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 16 | Read data from the SDRAM |

## Verification
The bench builds the controller with T_RCD=3, T_RP=2, T_RC=7 and REF_INTERVAL=60. These asymmetric timings make an off-by-one in any wait visible. The short refresh interval puts several refreshes inside a few hundred cycles of back-to-back traffic, so the refresh-versus-request ordering and the refresh spacing bound are hit many times. The bench runs both strap settings after separate resets. The init sequence is therefore seen twice, and the ignored upper address bits of the two-bank mode are tested by aliasing a write and a read.

// File: rtl/vram_sdram_pkg.sv
package vram_sdram_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESL = 4'b1111,
    CMD_NOP  = 4'b0111,
    CMD_ACT  = 4'b0011,
    CMD_RD   = 4'b0101,
    CMD_WR   = 4'b0100,
    CMD_PRE  = 4'b0010,
    CMD_REF  = 4'b0001,
    CMD_MRS  = 4'b0000
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PALL, ST_IREF1, ST_IREF2, ST_MRS, ST_IDLE, ST_RW, ST_WAIT
  } state_e;

  localparam int CAS_LAT = 2;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vram_addr_map.sv
module vram_addr_map #(
  parameter int COL_W  = 8,
  parameter int ROW_W  = 12,
  parameter int ADDR_W = 22,
  parameter int AP_BIT = 10
) (
  input  logic              small_mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        act_ba,
  output logic [ROW_W-1:0]  act_va,
  output logic [1:0]        rw_ba,
  output logic [ROW_W-1:0]  rw_va
);
  localparam int SB = ADDR_W - 3;  // bank bit of the two-bank layout

  always_comb begin
    rw_va = '0;
    rw_va[COL_W-1:0] = addr[COL_W-1:0];
    rw_va[AP_BIT] = 1'b1;
    if (small_mode) begin
      act_ba = 2'b00;
      act_va = {addr[SB], addr[SB-1:COL_W]};
      rw_ba  = 2'b00;
      rw_va[ROW_W-1] = addr[SB];
    end else begin
      act_ba = addr[ADDR_W-1 -: 2];
      act_va = addr[ADDR_W-3:COL_W];
      rw_ba  = act_ba;
    end
  end
endmodule

// File: rtl/vram_refresh_timer.sv
module vram_refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic service,
  output logic pending
);
  localparam int CW = $clog2(INTERVAL) + 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      if (service) pending <= 1'b0;
      if (cnt_q == CW'(INTERVAL - 1)) begin
        cnt_q   <= '0;
        pending <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vram_read_pipe.sv
module vram_read_pipe #(
  parameter int LAT = 2,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] dq_in,
  output logic          valid,
  output logic [DW-1:0] data
);
  logic [LAT:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      sh_q  <= {sh_q[LAT-1:0], issue};
      valid <= sh_q[LAT];
      if (sh_q[LAT]) data <= dq_in;
    end
  end
endmodule

// File: rtl/vram_sdram_ctrl.sv
module vram_sdram_ctrl
  import vram_sdram_pkg::*;
#(
  parameter int COL_W        = 8,
  parameter int ROW_W        = 12,
  parameter int ADDR_W       = ROW_W + COL_W + 2,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RC         = 6,
  parameter int T_MRD        = 2,
  parameter int REF_INTERVAL = 780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              small_mode,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ack,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              sd_dqm_hi,
  output logic              sd_dqm_lo,
  output logic [15:0]       sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [15:0]       sd_dq_in
);
  localparam int AP_BIT = 10;
  localparam int T_POST = max2(T_RC - T_RCD, T_RP + 2);
  localparam int WAIT_W = 8;

  function automatic logic [ROW_W-1:0] mrs_word();
    logic [ROW_W-1:0] w;
    w = '0;
    w[6:4] = 3'(CAS_LAT);  // burst length 1, sequential
    return w;
  endfunction

  state_e              state_q, nxt_q;
  cmd_e                cmd_q;
  logic [WAIT_W-1:0]   wcnt_q;
  logic [1:0]          ba_q, dqm_q;
  logic [ROW_W-1:0]    va_q;
  logic [15:0]         dq_q, lat_wd;
  logic                oe_q, ack_q, lat_we;
  logic [ADDR_W-1:0]   lat_addr;
  logic [1:0]          lat_be;

  // named internal events
  logic                in_idle, ref_pending, ref_service, rd_issue;
  logic [ADDR_W-1:0]   map_addr;
  logic [1:0]          act_ba, rw_ba;
  logic [ROW_W-1:0]    act_va, rw_va;

  assign in_idle     = (state_q == ST_IDLE);
  assign ref_service = in_idle && ref_pending;
  assign rd_issue    = (state_q == ST_RW) && !lat_we;
  assign map_addr    = in_idle ? req_addr : lat_addr;

  vram_addr_map #(.COL_W(COL_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_map (
    .small_mode(small_mode), .addr(map_addr),
    .act_ba(act_ba), .act_va(act_va), .rw_ba(rw_ba), .rw_va(rw_va)
  );

  vram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .service(ref_service), .pending(ref_pending)
  );

  vram_read_pipe #(.LAT(CAS_LAT), .DW(16)) u_rdp (
    .clk(clk), .rst_n(rst_n), .issue(rd_issue), .dq_in(sd_dq_in),
    .valid(rd_valid), .data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_PALL;
      nxt_q    <= ST_IDLE;
      wcnt_q   <= '0;
      cmd_q    <= CMD_DESL;
      ba_q     <= '0;
      va_q     <= '0;
      dqm_q    <= 2'b11;
      dq_q     <= '0;
      oe_q     <= 1'b0;
      ack_q    <= 1'b0;
      lat_we   <= 1'b0;
      lat_addr <= '0;
      lat_wd   <= '0;
      lat_be   <= '0;
    end else begin
      cmd_q <= CMD_DESL;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
      dqm_q <= 2'b11;
      case (state_q)
        ST_WAIT: begin
          if (wcnt_q == '0) state_q <= nxt_q;
          else              wcnt_q  <= wcnt_q - 1'b1;
        end
        ST_PALL: begin
          cmd_q   <= CMD_PRE;
          ba_q    <= '0;
          va_q    <= ROW_W'(1) << AP_BIT;
          state_q <= ST_WAIT;
          wcnt_q  <= WAIT_W'(T_RP - 2);
          nxt_q   <= ST_IREF1;
        end
        ST_IREF1, ST_IREF2: begin
          cmd_q   <= CMD_REF;
          state_q <= ST_WAIT;
          wcnt_q  <= WAIT_W'(T_RC - 2);
          nxt_q   <= (state_q == ST_IREF1) ? ST_IREF2 : ST_MRS;
        end
        ST_MRS: begin
          cmd_q   <= CMD_MRS;
          ba_q    <= '0;
          va_q    <= mrs_word();
          state_q <= ST_WAIT;
          wcnt_q  <= WAIT_W'(T_MRD - 2);
          nxt_q   <= ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pending) begin
            cmd_q   <= CMD_REF;
            state_q <= ST_WAIT;
            wcnt_q  <= WAIT_W'(T_RC - 2);
            nxt_q   <= ST_IDLE;
          end else if (req) begin
            cmd_q    <= CMD_ACT;
            ack_q    <= 1'b1;
            ba_q     <= act_ba;
            va_q     <= act_va;
            lat_we   <= req_we;
            lat_addr <= req_addr;
            lat_wd   <= req_wdata;
            lat_be   <= req_be;
            state_q  <= ST_WAIT;
            wcnt_q   <= WAIT_W'(T_RCD - 2);
            nxt_q    <= ST_RW;
          end
        end
        ST_RW: begin
          cmd_q <= lat_we ? CMD_WR : CMD_RD;
          ba_q  <= rw_ba;
          va_q  <= rw_va;
          if (lat_we) begin
            dq_q  <= lat_wd;
            oe_q  <= 1'b1;
            dqm_q <= ~lat_be;
          end else begin
            dqm_q <= 2'b00;
          end
          state_q <= ST_WAIT;
          wcnt_q  <= WAIT_W'(T_POST - 2);
          nxt_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = va_q;
  assign sd_dqm_hi = dqm_q[1];
  assign sd_dqm_lo = dqm_q[0];
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;
  assign req_ack   = ack_q;
endmodule

// File: rtl/vram_sdram_ctrl_chk.sv
module vram_sdram_ctrl_chk #(
  parameter int ROW_W = 12,
  parameter int T_RCD = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             small_mode,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [1:0]       sd_ba,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_dq_oe,
  input logic             req_ack,
  input logic             rd_valid,
  input logic             ref_pending,
  input logic             in_idle
);
  logic [3:0] bus;
  logic       is_act, is_rd, is_wr, is_ref, is_mrs;
  logic [7:0] act_age;

  assign bus    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_act = (bus == 4'b0011);
  assign is_rd  = (bus == 4'b0101);
  assign is_wr  = (bus == 4'b0100);
  assign is_ref = (bus == 4'b0001);
  assign is_mrs = (bus == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 act_age <= 8'hFF;
    else if (is_act)            act_age <= 8'd1;
    else if (act_age != 8'hFF)  act_age <= act_age + 8'd1;
  end

  p_mode_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (sd_addr == ROW_W'(12'h020) && sd_ba == 2'b00));
  p_no_sel_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> !(sd_ras_n && sd_cas_n && sd_we_n));
  p_small_bank_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (small_mode && !sd_cs_n) |-> (sd_ba == 2'b00));
  p_autopre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr) |-> sd_addr[10]);
  p_rcd_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr) |-> (act_age == 8'(T_RCD)));
  p_refresh_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pending && in_idle) |=> is_ref);
  p_ack_on_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> is_act);
  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);
  p_oe_only_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> is_wr);
  p_rd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_rd_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(is_rd, 3));
endmodule

bind vram_sdram_ctrl vram_sdram_ctrl_chk #(.ROW_W(ROW_W), .T_RCD(T_RCD)) u_chk (
  .clk(clk), .rst_n(rst_n), .small_mode(small_mode),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe),
  .req_ack(req_ack), .rd_valid(rd_valid),
  .ref_pending(ref_pending), .in_idle(in_idle)
);

// File: tb/vram_sdram_ctrl_tb.sv
module vram_sdram_ctrl_tb;
  localparam int COL_W = 8, ROW_W = 12, ADDR_W = 22;
  localparam int T_RCD = 3, T_RP = 2, T_RC = 7, T_MRD = 2, REF_INT = 60;
  localparam int SLACK = 9;  // T_RCD + max(T_RC-T_RCD, T_RP+2) + 2

  logic clk = 1'b0, rst_n = 1'b0, small_mode = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ack, rd_valid;
  logic [15:0] rd_data;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm_hi, sd_dqm_lo, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [ROW_W-1:0] sd_addr;
  logic [15:0] sd_dq_out;
  logic [15:0] sd_dq_in = 16'hBAD0;

  always #5 clk = ~clk;

  vram_sdram_ctrl #(.COL_W(COL_W), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RC(T_RC), .T_MRD(T_MRD), .REF_INTERVAL(REF_INT)) u_dut (
    .clk(clk), .rst_n(rst_n), .small_mode(small_mode), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_ack(req_ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dqm_hi(sd_dqm_hi), .sd_dqm_lo(sd_dqm_lo), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard and memory model state
  logic [15:0] shadow [int];
  logic [15:0] mem [int];
  logic [15:0] expq [$];
  int rdq [$];
  logic [11:0] open_row [4];
  int cyc = 0, init_idx = 0, last_act = -1000, last_ref = -1000, last_pre = -1000;
  int last_run_ref = -1, ref_runs = 0, rd_dly = 0;
  bit hold = 0;
  logic [15:0] rd_word;

  // memory model and protocol monitor, sampled mid-cycle
  always @(negedge clk) begin
    logic [3:0] c; logic [1:0] bk; logic [11:0] rw; int key; bit init_ph;
    cyc++;
    if (!rst_n) begin
      init_idx = 0; last_act = -1000; last_ref = -1000; last_pre = -1000;
      last_run_ref = -1; ref_runs = 0; rd_dly = 0; hold = 0; rdq.delete();
      sd_dq_in = 16'hBAD0;
    end else begin
      if (hold) begin sd_dq_in = 16'hBAD0; hold = 0; end
      if (rd_dly > 0) begin
        rd_dly--;
        if (rd_dly == 0) begin sd_dq_in = rd_word; hold = 1; end
      end
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      bk = small_mode ? {1'b0, sd_addr[11]} : sd_ba;
      init_ph = (init_idx < 4);
      if (!sd_cs_n) begin
        check(c != 4'b0111, "R2 selected NOP", c, 4'b0011);
        if (init_ph) begin
          case (init_idx)
            0: begin check(c == 4'b0010, "R1 first cmd PALL", c, 4'b0010);
                     check(sd_addr[10], "R1 PALL all banks", sd_addr, 12'h400); end
            1, 2: check(c == 4'b0001, "R1 init refresh", c, 4'b0001);
            default: begin check(c == 4'b0000, "R1 mode set", c, 4'b0000);
                     check(sd_addr == 12'h020 && sd_ba == 0, "R1 mode word", {sd_ba, sd_addr}, 12'h020); end
          endcase
          init_idx++;
        end
        check(cyc - last_pre >= T_RP, "R6 after precharge", cyc - last_pre, T_RP);
        if (c == 4'b0011 || c == 4'b0001 || c == 4'b0000)
          check(cyc - last_ref >= T_RC, "R7 after refresh", cyc - last_ref, T_RC);
        case (c)
          4'b0011: begin
            check(cyc - last_act >= T_RC, "R6 act to act", cyc - last_act, T_RC);
            open_row[bk] = small_mode ? {1'b0, sd_addr[10:0]} : sd_addr;
            last_act = cyc;
          end
          4'b0101, 4'b0100: begin
            check(cyc - last_act == T_RCD, "R6 act to column", cyc - last_act, T_RCD);
            rw = open_row[bk];
            key = {bk, rw, sd_addr[7:0]};
            if (c == 4'b0100) begin
              rd_word = mem.exists(key) ? mem[key] : 16'h0000;
              if (!sd_dqm_hi) rd_word[15:8] = sd_dq_out[15:8];
              if (!sd_dqm_lo) rd_word[7:0]  = sd_dq_out[7:0];
              mem[key] = rd_word;
            end else begin
              rd_word = mem.exists(key) ? mem[key] : 16'h0000;
              rd_dly = 2;
              rdq.push_back(cyc);
            end
          end
          4'b0010: last_pre = cyc;
          4'b0001: begin
            if (!init_ph) begin
              if (last_run_ref >= 0)
                check(cyc - last_run_ref <= REF_INT + SLACK && cyc - last_run_ref >= REF_INT - SLACK,
                      "R7 refresh spacing", cyc - last_run_ref, REF_INT);
              last_run_ref = cyc;
              ref_runs++;
            end
            last_ref = cyc;
          end
          default: ;
        endcase
      end
      if (c != 4'b0100) check(!sd_dq_oe, "R10 oe outside write", sd_dq_oe, 0);
      if (rd_valid) begin
        if (rdq.size() == 0) check(0, "R11 spurious rd_valid", 1, 0);
        else check(rdq.pop_front() + 3 == cyc, "R11 read latency", cyc, 3);
        if (expq.size() == 0) check(0, "R11 no expected item", rd_data, 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          check(rd_data == e, "R11 read data", rd_data, e);
        end
      end
    end
  end

  task automatic do_req(input bit we, input logic [21:0] a, input logic [15:0] wd, input logic [1:0] be);
    logic [1:0] eba; logic [11:0] eva, cva; logic [15:0] old; int key, lim; string mt;
    mt = small_mode ? "R4" : "R3";
    if (small_mode) begin
      eba = 2'd0;
      eva = {a[19], a[18:8]};
      cva = {a[19], 3'b100, a[7:0]};
      key = int'(a & 22'h0FFFFF);
    end else begin
      eba = a[21:20];
      eva = a[19:8];
      cva = {4'b0100, a[7:0]};
      key = int'(a);
    end
    @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = wd; req_be = be;
    lim = 0;
    do begin @(negedge clk); lim++; end while (!req_ack && lim < 200);
    req = 0;
    check(req_ack, "R9 request acknowledged", req_ack, 1);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011, "R9 ack with ACTIVATE",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0011);
    check(sd_ba == eba, {mt, " activate bank"}, sd_ba, eba);
    check(sd_addr == eva, {mt, " activate row"}, sd_addr, eva);
    old = shadow.exists(key) ? shadow[key] : 16'h0000;
    if (we) begin
      if (be[1]) old[15:8] = wd[15:8];
      if (be[0]) old[7:0] = wd[7:0];
      shadow[key] = old;
    end else expq.push_back(old);
    @(negedge clk);
    check(!req_ack, "R9 ack one cycle", req_ack, 0);
    repeat (T_RCD - 1) @(negedge clk);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == (we ? 4'b0100 : 4'b0101), "R6 column command",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, we ? 4'b0100 : 4'b0101);
    check(sd_addr == cva, "R5 column address with auto-precharge", sd_addr, cva);
    check(sd_ba == eba, {mt, " column bank"}, sd_ba, eba);
    if (we) begin
      check(sd_dq_oe && sd_dq_out == wd, "R10 write data", sd_dq_out, wd);
      check({sd_dqm_hi, sd_dqm_lo} == ~be, "R10 byte masks", {sd_dqm_hi, sd_dqm_lo}, ~be);
    end
  endtask

  task automatic reset_phase(input bit sm);
    rst_n = 0; small_mode = sm;
    repeat (4) @(negedge clk);
    check(sd_cs_n && !req_ack && !rd_valid && !sd_dq_oe, "R2 reset outputs idle",
          {sd_cs_n, req_ack, rd_valid, sd_dq_oe}, 4'b1000);
    rst_n = 1;
    repeat (25) @(negedge clk);
    check(init_idx == 4, "R1 init sequence complete", init_idx, 4);
  endtask

  task automatic drain(input string tag);
    repeat (20) @(negedge clk);
    check(expq.size() == 0, tag, expq.size(), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    // four-bank layout
    reset_phase(1'b0);
    do_req(1, 22'h3ABCDE, 16'h1234, 2'b11);
    do_req(0, 22'h3ABCDE, 16'h0, 2'b11);
    do_req(1, 22'h000000, 16'hCAFE, 2'b11);
    do_req(1, 22'h0000FF, 16'hBEEF, 2'b11);
    do_req(1, 22'h3ABCDE, 16'hAA55, 2'b01);   // low byte only
    do_req(0, 22'h3ABCDE, 16'h0, 2'b11);
    do_req(1, 22'h3ABCDE, 16'h77EE, 2'b10);   // high byte only
    do_req(0, 22'h3ABCDE, 16'h0, 2'b11);
    do_req(0, 22'h000000, 16'h0, 2'b11);
    do_req(0, 22'h0000FF, 16'h0, 2'b11);
    // back-to-back load across several refresh intervals (R7, R8)
    for (int i = 0; i < 40; i++)
      do_req(i[0], {i[1:0], 12'(i * 37), 8'(i * 3)} & 22'h3FFFFE | 22'(i[0] ? 0 : 0),
             16'(i * 16'h0101 + 16'h0F00), 2'b11);
    drain("R11 all reads returned four-bank");
    check(ref_runs >= 5, "R7 refreshes under load", ref_runs, 5);

    // two-bank layout
    reset_phase(1'b1);
    do_req(1, 22'h3F8001, 16'h5A5A, 2'b11);   // bits 21:20 set, ignored
    do_req(0, 22'h0F8001, 16'h0, 2'b11);
    do_req(1, 22'h080010, 16'h1357, 2'b11);   // bank 1
    do_req(1, 22'h000010, 16'h2468, 2'b11);   // bank 0, same row/col
    do_req(0, 22'h080010, 16'h0, 2'b11);
    do_req(0, 22'h000010, 16'h0, 2'b11);
    do_req(1, 22'h07FFFF, 16'hF00F, 2'b10);
    do_req(0, 22'h37FFFF, 16'h0, 2'b11);      // alias of the previous address
    repeat (200) @(negedge clk);
    drain("R11 all reads returned two-bank");
    check(ref_runs >= 3, "R7 idle refreshes", ref_runs, 3);
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R7 watchdog actual=timeout expected=finished");
      summary();
    end
  end
endmodule